// File: doc/BRIEF.md
# Peak-Current-Mode PWM Switch Controller

This block is the digital control core of a current-mode switching regulator. A free-running period counter stands in for the oscillator ramp. It splits each switching period into a long charge portion and a short discharge portion. The power switch gate command rises at the start of every period. It falls again in three cases: a current-sense comparator flag reports that the sensed inductor current has passed the error-amplifier level, a separate overcurrent flag trips, or the charge portion runs out. The charge portion is the maximum duty cycle. Once the gate has fallen it stays low until the next period start, so a comparator that chatters cannot turn it back on within the same period.

An active-high shutdown pin holds the switch off. A select pin chooses which of two feedback inputs the external multiplexer uses. The select pin reads high when it is left open, so its default is the second feedback input. Both pins pass through synchronisers. A new select value takes effect only at a period boundary. A two-bit status output reports how the previous period ended.

Top module: `pwm_cm_ctrl`

## Requirements
- R1: During and right after reset, `gate_o` is 0, `fb_sel_o` is 1 (second feedback input) and `status_o` is 0 (none). The period counter starts at phase 0.
- R2: The period is PERIOD_CYC clocks. The gate is high in phase 0 of every period while shutdown is inactive. A rise of the gate is the only event that marks the start of a period.
- R3: If `cs_trip_i` is 1 while the gate is high, the gate is low from the next clock on. It stays low for the rest of the period, even if the flag falls or toggles afterwards.
- R4: Without any trip, the gate is high for exactly CHARGE_CYC clocks per period (phases 0 to CHARGE_CYC-1), and never longer.
- R5: `ilim_i` ends the on-time in the same way as `cs_trip_i` and independently of it.
- R6: When `shdn_i` is sampled high, the gate is low from the third clock on, and it stays low while the pin stays high. After the pin returns low, switching resumes at the next period start.
- R7: `fb_sel_o` follows the synchronised `sel_i` (0 selects feedback input 1, 1 selects feedback input 2). It changes only when a new period starts.
- R8: At each period start, `status_o` takes the code for how the previous period ended: 0 = no on-time ended (shutdown), 1 = comparator trip, 2 = overcurrent, 3 = duty cap. If both flags are seen in the same clock, the code is 2. A trip in the last charge clock gives code 1 or 2, not 3.
- R9: Trip flags that arrive while the gate is already low have no effect on the gate or on the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_i | input | 1 | Shutdown, high holds the switch off (asynchronous) |
| sel_i | input | 1 | Feedback select, low = input 1, high/open = input 2 (asynchronous) |
| cs_trip_i | input | 1 | Current-sense comparator flag, sensed current above error level |
| ilim_i | input | 1 | Switch overcurrent flag |
| gate_o | output | 1 | Power switch gate command |
| fb_sel_o | output | 1 | Feedback multiplexer select code |
| status_o | output | 2 | How the previous period ended |

## Verification
The gate is driven through several kinds of periods, and each kind shows a different way the on-time can end:
- With no trips, the gate runs into the duty cap.
- A comparator pulse mid-period is followed by chatter. This separates a latched turn-off from one that simply follows the flag.
- An overcurrent pulse and a simultaneous dual trip show the priority between the two flags.
- A trip in the last charge clock shows the priority of a trip over the duty cap.
- Flags raised during the discharge portion show that late flags are ignored.

Shutdown is asserted in the middle of an on-time, and the select pin is toggled in the middle of a period. These show the synchroniser latency and that the select value only takes effect at a period boundary.

// File: rtl/pwm_cm_pkg.sv
package pwm_cm_pkg;

  typedef enum logic [1:0] {
    END_NONE  = 2'd0,
    END_TRIP  = 2'd1,
    END_LIMIT = 2'd2,
    END_DUTY  = 2'd3
  } end_cause_e;

endpackage

// File: rtl/pwm_cm_sync.sv
module pwm_cm_sync #(
  parameter int         STAGES  = 2,
  parameter logic       RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d_i;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pwm_cm_osc.sv
module pwm_cm_osc #(
  parameter int PERIOD_CYC = 100,
  parameter int CHARGE_CYC = 85,
  localparam int CW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] phase_o,
  output logic          wrap_o,
  output logic          duty_end_o
);

  localparam logic [CW-1:0] LAST_PH   = CW'(PERIOD_CYC - 1);
  localparam logic [CW-1:0] CHG_LAST  = CW'(CHARGE_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          wrap;

  assign wrap = (cnt_q == LAST_PH);

  always_comb begin
    if (wrap) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign phase_o    = cnt_q;
  assign wrap_o     = wrap;
  assign duty_end_o = (cnt_q == CHG_LAST);

endmodule

// File: rtl/pwm_cm_gate.sv
module pwm_cm_gate
  import pwm_cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrap_i,
  input  logic       duty_end_i,
  input  logic       dis_i,
  input  logic       sel_i,
  input  logic       cs_trip_i,
  input  logic       ilim_i,
  output logic       gate_o,
  output logic       fb_sel_o,
  output logic [1:0] status_o
);

  logic       gate_q,  gate_d;
  logic       sel_q,   sel_d;
  end_cause_e cur_q,   cur_d;
  end_cause_e last_q,  last_d;
  logic       last_en;

  // gate behaves as a set/reset latch: set only at a period boundary
  always_comb begin
    gate_d = gate_q;
    if (dis_i) begin
      gate_d = 1'b0;
    end else if (wrap_i) begin
      gate_d = 1'b1;
    end else if (gate_q && (cs_trip_i || ilim_i)) begin
      gate_d = 1'b0;
    end else if (gate_q && duty_end_i) begin
      gate_d = 1'b0;
    end
  end

  // cause of the running period's turn-off
  always_comb begin
    cur_d = cur_q;
    if (wrap_i) begin
      cur_d = END_NONE;
    end else if (dis_i) begin
      cur_d = END_NONE;
    end else if (gate_q && ilim_i) begin
      cur_d = END_LIMIT;
    end else if (gate_q && cs_trip_i) begin
      cur_d = END_TRIP;
    end else if (gate_q && duty_end_i) begin
      cur_d = END_DUTY;
    end
  end

  assign last_en = wrap_i;
  assign last_d  = cur_q;
  assign sel_d   = sel_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      cur_q  <= END_NONE;
    end else begin
      gate_q <= gate_d;
      cur_q  <= cur_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= END_NONE;
      sel_q  <= 1'b1;
    end else if (last_en) begin
      last_q <= last_d;
      sel_q  <= sel_d;
    end
  end

  assign gate_o   = gate_q;
  assign fb_sel_o = sel_q;
  assign status_o = last_q;

endmodule

// File: rtl/pwm_cm_ctrl.sv
module pwm_cm_ctrl #(
  parameter int PERIOD_CYC  = 100,
  parameter int CHARGE_CYC  = 85,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shdn_i,
  input  logic       sel_i,
  input  logic       cs_trip_i,
  input  logic       ilim_i,
  output logic       gate_o,
  output logic       fb_sel_o,
  output logic [1:0] status_o
);

  localparam int CW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;

  logic [CW-1:0] osc_phase;
  logic          osc_wrap;
  logic          osc_duty_end;
  logic          shdn_sync;
  logic          sel_sync;

  pwm_cm_osc #(
    .PERIOD_CYC (PERIOD_CYC),
    .CHARGE_CYC (CHARGE_CYC)
  ) u_osc (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_o    (osc_phase),
    .wrap_o     (osc_wrap),
    .duty_end_o (osc_duty_end)
  );

  pwm_cm_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync_shdn (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (shdn_i),
    .q_o   (shdn_sync)
  );

  pwm_cm_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (sel_i),
    .q_o   (sel_sync)
  );

  pwm_cm_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .wrap_i     (osc_wrap),
    .duty_end_i (osc_duty_end),
    .dis_i      (shdn_sync),
    .sel_i      (sel_sync),
    .cs_trip_i  (cs_trip_i),
    .ilim_i     (ilim_i),
    .gate_o     (gate_o),
    .fb_sel_o   (fb_sel_o),
    .status_o   (status_o)
  );

endmodule

// File: rtl/pwm_cm_ctrl_chk.sv
module pwm_cm_ctrl_chk #(
  parameter int CHARGE_CYC = 85
) (
  input logic       clk,
  input logic       rst_n,
  input logic       shdn_i,
  input logic       cs_trip_i,
  input logic       ilim_i,
  input logic       gate_o,
  input logic       fb_sel_o,
  input logic [1:0] status_o,
  input logic       wrap,
  input logic       dis_s
);

  localparam int RW = $clog2(CHARGE_CYC + 2) + 1;

  logic [RW-1:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
    end else if (gate_o) begin
      hi_run <= hi_run + RW'(1);
    end else begin
      hi_run <= '0;
    end
  end

  // R4
  max_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_run <= RW'(CHARGE_CYC));

  // R3
  trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o && (cs_trip_i || ilim_i) |=> !gate_o);

  // R3
  stay_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_o && !wrap |=> !gate_o);

  // R2
  period_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && !dis_s |=> gate_o);

  // R6
  shdn_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(shdn_i, 3) |-> !gate_o);

  // R7
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(fb_sel_o));

  // R8
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(status_o));

endmodule

bind pwm_cm_ctrl pwm_cm_ctrl_chk #(
  .CHARGE_CYC (CHARGE_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .shdn_i    (shdn_i),
  .cs_trip_i (cs_trip_i),
  .ilim_i    (ilim_i),
  .gate_o    (gate_o),
  .fb_sel_o  (fb_sel_o),
  .status_o  (status_o),
  .wrap      (osc_wrap),
  .dis_s     (shdn_sync)
);

// File: tb/pwm_cm_ctrl_test.sv
module pwm_cm_ctrl_test;

  localparam int P = 20;
  localparam int C = 17;

  logic       clk;
  logic       rst_n;
  logic       shdn_i;
  logic       sel_i;
  logic       cs_trip_i;
  logic       ilim_i;
  logic       gate_o;
  logic       fb_sel_o;
  logic [1:0] status_o;

  int checks;
  int errors;
  int cycles;
  string req_tag;

  // behavioural reference state
  int m_ph;
  bit m_gate;
  int m_cur;
  int m_last;
  bit m_sel;
  bit sh_q[$];
  bit sl_q[$];

  pwm_cm_ctrl #(
    .PERIOD_CYC (P),
    .CHARGE_CYC (C)
  ) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .shdn_i    (shdn_i),
    .sel_i     (sel_i),
    .cs_trip_i (cs_trip_i),
    .ilim_i    (ilim_i),
    .gate_o    (gate_o),
    .fb_sel_o  (fb_sel_o),
    .status_o  (status_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_gate = 0; m_cur = 0; m_last = 0; m_sel = 1;
      sh_q = '{1'b1, 1'b1};
      sl_q = '{1'b1, 1'b1};
    end else begin
      bit dis;
      bit sel_s;
      bit ng;
      int nc;
      bit wrap;
      dis = sh_q[1];
      sel_s = sl_q[1];
      wrap = (m_ph == P - 1);
      ng = m_gate;
      if (dis) ng = 0;
      else if (wrap) ng = 1;
      else if (m_gate && (cs_trip_i || ilim_i)) ng = 0;
      else if (m_gate && m_ph == C - 1) ng = 0;
      nc = m_cur;
      if (wrap) nc = 0;
      else if (dis) nc = 0;
      else if (m_gate && ilim_i) nc = 2;
      else if (m_gate && cs_trip_i) nc = 1;
      else if (m_gate && m_ph == C - 1) nc = 3;
      if (wrap) begin
        m_last = m_cur;
        m_sel = sel_s;
      end
      m_gate = ng;
      m_cur = nc;
      m_ph = wrap ? 0 : m_ph + 1;
      sh_q.push_front(shdn_i); void'(sh_q.pop_back());
      sl_q.push_front(sel_i);  void'(sl_q.pop_back());
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(req_tag, "gate_o", gate_o, m_gate);
      check(req_tag, "fb_sel_o", fb_sel_o, m_sel);
      check(req_tag, "status_o", status_o, m_last);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_ph(input int v);
    do @(negedge clk); while (m_ph != v);
  endtask

  task automatic periods(input int n);
    for (int i = 0; i < n; i++) wait_ph(P - 1);
  endtask

  initial begin
    int on_cnt;
    checks = 0; errors = 0; cycles = 0;
    req_tag = "R1";
    shdn_i = 0; sel_i = 1; cs_trip_i = 0; ilim_i = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "gate_o in reset", gate_o, 0);
    check("R1", "fb_sel_o in reset", fb_sel_o, 1);
    check("R1", "status_o in reset", status_o, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", "gate_o after reset", gate_o, 0);

    // R2 / R4: free run hits the duty cap
    req_tag = "R2";
    periods(2);
    req_tag = "R4";
    on_cnt = 0;
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      if (gate_o) on_cnt++;
    end
    check("R4", "on clocks per period", on_cnt, C);
    check("R8", "status after duty cap", status_o, 3);

    // R3: comparator trip with chatter
    req_tag = "R3";
    wait_ph(5); cs_trip_i = 1;
    @(negedge clk); cs_trip_i = 0;
    check("R3", "gate off after trip", gate_o, 0);
    @(negedge clk); cs_trip_i = 1;
    @(negedge clk); cs_trip_i = 0;
    @(negedge clk);
    check("R3", "gate stays off under chatter", gate_o, 0);
    wait_ph(0);
    check("R8", "status after comparator trip", status_o, 1);
    check("R2", "gate on at period start", gate_o, 1);

    // R5: overcurrent trip
    req_tag = "R5";
    wait_ph(8); ilim_i = 1;
    @(negedge clk); ilim_i = 0;
    check("R5", "gate off after limit", gate_o, 0);
    wait_ph(0);
    check("R8", "status after limit", status_o, 2);

    // R8: both flags same clock, limit wins
    req_tag = "R8";
    wait_ph(3); ilim_i = 1; cs_trip_i = 1;
    @(negedge clk); ilim_i = 0; cs_trip_i = 0;
    wait_ph(0);
    check("R8", "status dual trip", status_o, 2);

    // R8: trip in last charge clock beats duty cap
    wait_ph(C - 1); cs_trip_i = 1;
    @(negedge clk); cs_trip_i = 0;
    wait_ph(0);
    check("R8", "status trip at last charge clock", status_o, 1);

    // R9: flags while gate low are ignored
    req_tag = "R9";
    wait_ph(C + 1); cs_trip_i = 1; ilim_i = 1;
    @(negedge clk); cs_trip_i = 0; ilim_i = 0;
    wait_ph(0);
    check("R9", "status unaffected by late flags", status_o, 3);
    check("R9", "gate on after late flags", gate_o, 1);

    // R6: shutdown mid on-time
    req_tag = "R6";
    wait_ph(4); shdn_i = 1;
    @(negedge clk);
    check("R6", "gate still on one clock after", gate_o, 1);
    @(negedge clk);
    @(negedge clk);
    check("R6", "gate off third clock", gate_o, 0);
    periods(1);
    wait_ph(2);
    check("R6", "no pulse while shut down", gate_o, 0);
    check("R8", "status after shutdown period", status_o, 0);
    shdn_i = 0;
    periods(1);
    @(negedge clk);
    check("R6", "switching resumes", gate_o, 1);

    // R7: select changes only at a period boundary
    req_tag = "R7";
    wait_ph(6); sel_i = 0;
    repeat (4) @(negedge clk);
    check("R7", "fb_sel held mid period", fb_sel_o, 1);
    wait_ph(0);
    check("R7", "fb_sel input 1 at boundary", fb_sel_o, 0);
    wait_ph(10); sel_i = 1;
    wait_ph(0);
    check("R7", "fb_sel input 2 at boundary", fb_sel_o, 1);
    periods(1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule